// File: doc/BRIEF.md
# Early Transmit Underrun Address Guard

This block lets a transmitter begin sending a frame while the host is still writing that frame into buffer memory. It stops the DMA engine from reading past the host's last write. Each host write to buffer memory carries the physical memory address, not the host-side address. While checking is active, the block captures that address. Each DMA read of packet data is compared against the captured value. A read beyond the captured address trips a sticky underrun abort that stops the transmitter. The abort stays up until the DMA reports that it has flushed the transmit FIFO. The trip itself is signalled as a one-cycle underrun status event and a one-cycle transmit-error interrupt event, in the same way a FIFO underrun is reported.

Checking is switched by a two-bit command written on a command strobe. `cmd_code[1]` requests checking on and `cmd_code[0]` requests checking off. A write with neither bit set keeps the current state. A write with both bits set is illegal and is discarded. The host write, DMA read and flush inputs are observe-only qualifiers of transfers that another agent owns. The block never stalls them, so it has no ready signal and applies no back-pressure. A transfer counts in every cycle its strobe is high at a rising clock edge.

Top module: `etxu_guard`

## Requirements
- R1: A command write with `cmd_code` = 2'b10 turns checking on from the next cycle.
- R2: A command write with `cmd_code` = 2'b01 turns checking off from the next cycle; after reset checking is off.
- R3: A command write with `cmd_code` = 2'b00 leaves the checking state unchanged.
- R4: A command write with `cmd_code` = 2'b11 is ignored and leaves the checking state unchanged.
- R5: While checking is on, every host write (`hw_valid`) captures `hw_addr`. Host writes made while checking is off capture nothing.
- R6: The captured address is zero after reset. It is also cleared to zero by every accepted turn-on command, and that clearing overrides a host write in the same cycle.
- R7: While checking is on, a DMA packet-data read whose `dr_addr` is strictly greater than the captured address raises `tx_abort` in the next cycle. A read at an equal or lower address does not.
- R8: DMA reads flagged as descriptor accesses (`dr_is_desc` = 1) never raise an abort. Reads made while checking is off never raise an abort.
- R9: `tx_abort` stays high until a cycle with `flush_ack` high and drops in the following cycle. A violating read in the same cycle as `flush_ack` keeps it high.
- R10: `urun_evt` and `txerr_evt` are both high for exactly the one cycle in which `tx_abort` first rises. They stay low while an abort that is already active is hit again.
- R11: After reset, `tx_abort`, `urun_evt` and `txerr_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 2 | Bit 1 turns checking on, bit 0 turns checking off |
| hw_valid | input | 1 | Host write to buffer memory this cycle |
| hw_addr | input | AW | Physical memory address of the host write |
| dr_valid | input | 1 | DMA read of buffer memory this cycle |
| dr_addr | input | AW | Memory address of the DMA read |
| dr_is_desc | input | 1 | The DMA read targets a descriptor entry |
| flush_ack | input | 1 | DMA has seen the abort and flushed the transmit FIFO |
| tx_abort | output | 1 | Buffer-underrun abort to the transmitter |
| urun_evt | output | 1 | One-cycle underrun status event |
| txerr_evt | output | 1 | One-cycle transmit-error interrupt event |

## Verification
The hardest states to reach are the collisions between inputs in the same cycle. One is a turn-on command arriving together with a host write. Another is a violating read arriving together with a flush acknowledgement, which must keep the abort up without a second event. Dedicated drive steps assert these inputs together at one edge. Before that, a full sweep of every captured address against every read address in a five-bit configuration sets up the comparison boundary. The checking state has no output of its own, so it is observed by issuing a read at the top address and watching whether an abort appears.

// File: rtl/etxu_pkg.sv
package etxu_pkg;
  // Command field: bit 1 requests checking on, bit 0 requests it off.
  typedef enum logic [1:0] {
    ETXU_HOLD = 2'b00,
    ETXU_OFF  = 2'b01,
    ETXU_ON   = 2'b10,
    ETXU_BAD  = 2'b11
  } etxu_cmd_e;
endpackage

// File: rtl/etxu_cmd_ctrl.sv
module etxu_cmd_ctrl
  import etxu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_code,
  output logic       check_on,
  output logic       arm_pulse
);
  etxu_cmd_e code;
  logic      next_on;

  always_comb begin
    code      = etxu_cmd_e'(cmd_code);
    next_on   = check_on;
    arm_pulse = 1'b0;
    if (cmd_wr) begin
      unique case (code)
        ETXU_ON:  begin next_on = 1'b1; arm_pulse = 1'b1; end
        ETXU_OFF: next_on = 1'b0;
        default:  next_on = check_on;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) check_on <= 1'b0;
    else        check_on <= next_on;
  end

  // R3: the hold code keeps the checking state
  a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b00) |=> $stable(check_on));
  // R4: the both-ones code is discarded
  a_r4_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b11) |=> $stable(check_on));
  // R1: the turn-on code takes effect next cycle
  a_r1_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b10) |=> check_on);
  // R2: the turn-off code takes effect next cycle
  a_r2_turn_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b01) |=> !check_on);
endmodule

// File: rtl/etxu_addr_latch.sv
module etxu_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (clear)   addr_q <= '0;
    else if (capture) addr_q <= addr_in;
  end

  // R5: a capture without a clear loads the presented address
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clear) |=> addr_q == $past(addr_in));
  // R6: a clear empties the latch
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> addr_q == '0);
endmodule

// File: rtl/etxu_overrun_detect.sv
module etxu_overrun_detect #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          check_on,
  input  logic          rd_valid,
  input  logic          rd_is_desc,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_mark,
  input  logic          flush_ack,
  output logic          abort_q,
  output logic          event_q
);
  logic ahead;
  logic trip;

  always_comb begin
    ahead = rd_addr > wr_mark;
    trip  = check_on && rd_valid && !rd_is_desc && ahead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= trip && !abort_q;
      if (trip)           abort_q <= 1'b1;
      else if (flush_ack) abort_q <= 1'b0;
    end
  end

  // R8: an abort only starts from a packet-data read while checking
  a_r8_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> $past(rd_valid && !rd_is_desc && check_on));
  // R9: the abort only falls after a flush acknowledgement
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_q) |-> $past(flush_ack));
  // R10: the event marks exactly the rising cycle of the abort
  a_r10_event_rise: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> $rose(abort_q));
endmodule

// File: rtl/etxu_guard.sv
module etxu_guard
  import etxu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [1:0]    cmd_code,
  input  logic          hw_valid,
  input  logic [AW-1:0] hw_addr,
  input  logic          dr_valid,
  input  logic [AW-1:0] dr_addr,
  input  logic          dr_is_desc,
  input  logic          flush_ack,
  output logic          tx_abort,
  output logic          urun_evt,
  output logic          txerr_evt
);
  logic          check_on;
  logic          arm_pulse;
  logic [AW-1:0] wr_mark;
  logic          evt;

  etxu_cmd_ctrl u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_code  (cmd_code),
    .check_on  (check_on),
    .arm_pulse (arm_pulse)
  );

  etxu_addr_latch #(.AW(AW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (arm_pulse),
    .capture (check_on && hw_valid),
    .addr_in (hw_addr),
    .addr_q  (wr_mark)
  );

  etxu_overrun_detect #(.AW(AW)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .check_on   (check_on),
    .rd_valid   (dr_valid),
    .rd_is_desc (dr_is_desc),
    .rd_addr    (dr_addr),
    .wr_mark    (wr_mark),
    .flush_ack  (flush_ack),
    .abort_q    (tx_abort),
    .event_q    (evt)
  );

  assign urun_evt  = evt;
  assign txerr_evt = evt;

  // R10: both reports appear only alongside an active abort
  a_r10_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_evt || txerr_evt) |-> tx_abort);
  // R8: descriptor reads never start an abort
  a_r8_desc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && dr_is_desc && !tx_abort) |=> !$rose(tx_abort));
endmodule

// File: tb/etxu_guard_bench.sv
module etxu_guard_bench;
  localparam int AW = 5;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, hw_valid = 0, dr_valid = 0, dr_is_desc = 0, flush_ack = 0;
  logic [1:0] cmd_code = 0;
  logic [AW-1:0] hw_addr = 0, dr_addr = 0;
  logic tx_abort, urun_evt, txerr_evt;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_on = 0;
  int m_lat = 0;
  bit m_abort = 0;

  always #2.5 clk = ~clk;

  etxu_guard #(.AW(AW)) u_etxu_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .hw_valid(hw_valid), .hw_addr(hw_addr), .dr_valid(dr_valid),
    .dr_addr(dr_addr), .dr_is_desc(dr_is_desc), .flush_ack(flush_ack),
    .tx_abort(tx_abort), .urun_evt(urun_evt), .txerr_evt(txerr_evt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle of stimulus; the model follows the requirements, then outputs are compared.
  task automatic step(input string req, input bit cw, input logic [1:0] cc,
                      input bit hv, input int ha, input bit dv, input int da,
                      input bit dd, input bit fl);
    bit trip;
    bit exp_evt;
    @(negedge clk);
    cmd_wr = cw; cmd_code = cc; hw_valid = hv; hw_addr = AW'(ha);
    dr_valid = dv; dr_addr = AW'(da); dr_is_desc = dd; flush_ack = fl;
    trip = m_on && dv && !dd && (da > m_lat);          // R7, R8
    exp_evt = trip && !m_abort;                        // R10
    if (trip) m_abort = 1;                             // R9 set wins
    else if (fl) m_abort = 0;
    if (cw && cc == 2'b10) m_lat = 0;                  // R6
    else if (m_on && hv) m_lat = ha;                   // R5
    if (cw && cc == 2'b10) m_on = 1;                   // R1
    else if (cw && cc == 2'b01) m_on = 0;              // R2; R3/R4 hold
    @(negedge clk);
    cmd_wr = 0; hw_valid = 0; dr_valid = 0; dr_is_desc = 0; flush_ack = 0;
    chk({req, " abort"}, tx_abort, m_abort);
    chk({req, " urun_evt"}, urun_evt, exp_evt);
    chk({req, " txerr_evt"}, txerr_evt, exp_evt);
  endtask

  task automatic cmd(input string req, input logic [1:0] c);
    step(req, 1, c, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic hwr(input string req, input int a);
    step(req, 0, 2'b00, 1, a, 0, 0, 0, 0);
  endtask
  task automatic drd(input string req, input int a, input bit d);
    step(req, 0, 2'b00, 0, 0, 1, a, d, 0);
  endtask
  task automatic flush(input string req);
    step(req, 0, 2'b00, 0, 0, 0, 0, 0, 1);
  endtask
  // Probe checking state: a read at the top address trips only when on (latch below top).
  task automatic probe(input string req);
    drd(req, TOP, 0);
    flush(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 abort", tx_abort, 0);
    chk("R11 urun_evt", urun_evt, 0);
    chk("R11 txerr_evt", txerr_evt, 0);
    rst_n = 1;
    // R2: off after reset, reads do not trip
    probe("R2 off after reset");
    hwr("R5 write while off", 7);
    // R1: turn on, latch zero (R6)
    cmd("R1 turn on", 2'b10);
    drd("R6 latch zero after enable", 1, 0);
    flush("R9 flush");
    // R7 sweep: every latched address against every read address
    for (int w = 0; w <= TOP; w++) begin
      for (int r = 0; r <= TOP; r++) begin
        hwr("R5 capture", w);
        drd("R7 compare", r, 0);
        if (m_abort) flush("R9 release");
      end
    end
    // R8: descriptor reads never trip
    hwr("R5 capture", 3);
    for (int r = 0; r <= TOP; r++) drd("R8 descriptor read", r, 1);
    // R3 / R4 while on
    cmd("R3 hold while on", 2'b00);
    probe("R3 still on");
    cmd("R4 illegal while on", 2'b11);
    probe("R4 still on");
    // R6: re-enable clears latch; override same-cycle host write
    hwr("R5 capture", 20);
    drd("R7 equal no trip", 20, 0);
    step("R6 enable beats write", 1, 2'b10, 1, 25, 0, 0, 0, 0);
    drd("R6 cleared latch trips", 1, 0);
    // R9/R10: repeat violation and same-cycle flush keep abort, no new event
    drd("R10 no second event", 2, 0);
    step("R9 trip beats flush", 0, 2'b00, 0, 0, 1, 3, 0, 1);
    chk("R9 abort held", tx_abort, 1);
    flush("R9 release");
    chk("R9 released", tx_abort, 0);
    // R2: turn off, reads ignored, writes not captured
    cmd("R2 turn off", 2'b01);
    probe("R8 off no trip");
    hwr("R5 write while off", 30);
    cmd("R4 illegal while off", 2'b11);
    probe("R4 still off");
    cmd("R3 hold while off", 2'b00);
    probe("R3 still off");
    // R5: write while off not captured once re-enabled (latch reset to 0 anyway)
    cmd("R1 turn on again", 2'b10);
    drd("R5 old write not kept", 10, 0);
    flush("R9 release");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule